// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block is an integer address unit for a load/store datapath. It keeps a private file of 32 general registers, each 32 bits wide. It accepts one operation per cycle. An address operation names a pointer register and a modifier. The modifier is another register or a sign-extended immediate. The unit then emits the memory address for that access on the following cycle.

Pre-modify emits pointer plus modifier and leaves the pointer alone. Post-modify emits the unmodified pointer and stores pointer plus modifier back into it. Pointer registers 0 to 3 each own a base and a length. When the length is nonzero, the updated value stays inside the window [base, base+length). That window can sit at any address, with no alignment to a power of two.

The same register file also serves plain integer work: add, subtract, AND, OR and immediate load. These ops are not pipelined, so a result written at one clock edge is readable through the read port straight after it. Memory itself lies outside the block.

Top module: `circ_agu`

## Requirements
- R1: Synchronous active-high reset clears all 32 registers, every base and every length to zero. It also drives addr_valid low and addr_out to zero.
- R2: op_code 7 (load) writes imm into register dst_sel. rd_data, selected by rd_sel, shows the new value after the clock edge that performs the write.
- R3: op_code 1 (pre-modify) raises addr_valid one cycle later, with addr_out equal to the pointer plus the modifier (after wrap). The pointer register keeps its value.
- R4: op_code 2 (post-modify) raises addr_valid one cycle later, with addr_out equal to the pointer value before the op. The pointer register receives pointer plus modifier (after wrap).
- R5: mod_kind selects the modifier as follows:
  - 0: register mod_reg.
  - 1: imm[7:0], sign-extended.
  - 2: all 32 bits of imm.
  - 3: zero.
- R6: Wrap applies when ptr_sel is 0 to 3 and its length is nonzero. The sum is first formed as pointer plus modifier. A sum at or above base+length has the length subtracted. A sum below base has the length added. op_code 8 loads the base of pointer ptr_sel from imm, and op_code 9 loads its length.
- R7: With length zero, or with ptr_sel of 4 or more, the update is linear 32-bit addition. Base and length writes that name ptr_sel of 4 or more change nothing.
- R8: op_codes 3, 4, 5 and 6 write register dst_sel with reg[ptr_sel] plus, minus, AND, OR the modifier respectively. The result is readable after the next clock edge.
- R9: While op_valid is low, no register changes and addr_valid is low on the next cycle. op_code 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code |
| ptr_sel | input | 5 | Pointer / first operand register |
| dst_sel | input | 5 | Destination register for load and ALU ops |
| mod_kind | input | 2 | Modifier source select |
| mod_reg | input | 5 | Modifier register index |
| imm | input | 32 | Immediate value |
| rd_sel | input | 5 | Read port register index |
| rd_data | output | 32 | Read port data |
| addr_valid | output | 1 | Address output valid |
| addr_out | output | 32 | Generated memory address |

## Verification
The bench builds the block with its default parameters: 32 registers, 32-bit data and 4 circular pointers. This lets it exercise both the circular registers 0 to 3 and a linear register at index 4. A 12-entry window at base 1000 is stepped across its upper and lower edges, including a landing exactly on base+length. A 32-bit wrap-around of a linear pointer covers the case where no window applies. Negative 8-bit immediates such as 0x80 and 0xFB check sign extension inside both the address path and the ALU path.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int DATA_W = 32;
    localparam int NREG   = 32;
    localparam int NCIRC  = 4;
    localparam int SEL_W  = $clog2(NREG);

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_PRE   = 4'd1,
        OP_POST  = 4'd2,
        OP_ADD   = 4'd3,
        OP_SUB   = 4'd4,
        OP_AND   = 4'd5,
        OP_OR    = 4'd6,
        OP_LOAD  = 4'd7,
        OP_SBASE = 4'd8,
        OP_SLEN  = 4'd9
    } agu_op_e;

    typedef enum logic [1:0] {
        MK_REG  = 2'd0,
        MK_IMM8 = 2'd1,
        MK_IMM  = 2'd2,
        MK_ZERO = 2'd3
    } mod_kind_e;

    typedef struct packed {
        agu_op_e          op;
        logic [SEL_W-1:0] ptr;
        logic [SEL_W-1:0] dst;
        mod_kind_e        mk;
        logic [SEL_W-1:0] mreg;
        logic [DATA_W-1:0] imm;
    } agu_req_t;

    function automatic logic [DATA_W-1:0] sext8(input logic [7:0] v);
        return {{(DATA_W-8){v[7]}}, v};
    endfunction

    function automatic logic is_addr_op(input agu_op_e op);
        return (op == OP_PRE) || (op == OP_POST);
    endfunction

endpackage

// File: rtl/agu_regfile.sv
module agu_regfile #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int SW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [SW-1:0] wsel,
    input  logic [W-1:0]  wdata,
    input  logic [SW-1:0] a_sel,
    input  logic [SW-1:0] b_sel,
    input  logic [SW-1:0] c_sel,
    output logic [W-1:0]  a_data,
    output logic [W-1:0]  b_data,
    output logic [W-1:0]  c_data
);
    logic [W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (we && wsel == SW'(i))
                mem[i] <= wdata;
        end
    end

    assign a_data = mem[a_sel];
    assign b_data = mem[b_sel];
    assign c_data = mem[c_sel];
endmodule

// File: rtl/agu_circ_ctx.sv
module agu_circ_ctx #(
    parameter int W     = 32,
    parameter int NCIRC = 4,
    parameter int SW    = 5,
    localparam int CW   = (NCIRC > 1) ? $clog2(NCIRC) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          base_we,
    input  logic          len_we,
    input  logic [SW-1:0] sel,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  base_val,
    output logic [W-1:0]  len_val,
    output logic          circ_on
);
    logic [W-1:0] base_q [NCIRC];
    logic [W-1:0] len_q  [NCIRC];
    logic         in_rng;
    logic [CW-1:0] idx;

    assign in_rng = (sel < SW'(NCIRC));
    assign idx    = CW'(sel);

    for (genvar i = 0; i < NCIRC; i++) begin : g_ctx
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[i] <= '0;
                len_q[i]  <= '0;
            end else if (in_rng && idx == CW'(i)) begin
                if (base_we) base_q[i] <= wdata;
                if (len_we)  len_q[i]  <= wdata;
            end
        end
    end

    assign base_val = in_rng ? base_q[idx] : '0;
    assign len_val  = in_rng ? len_q[idx]  : '0;
    assign circ_on  = in_rng && (len_val != '0);
endmodule

// File: rtl/agu_modwrap.sv
module agu_modwrap #(
    parameter int W = 32
) (
    input  logic [W-1:0] ptr,
    input  logic [W-1:0] modv,
    input  logic [W-1:0] base,
    input  logic [W-1:0] len,
    input  logic         circ_on,
    output logic [W-1:0] next_addr
);
    logic [W-1:0] sum;
    logic [W-1:0] top;

    assign sum = ptr + modv;
    assign top = base + len;

    always_comb begin
        next_addr = sum;
        if (circ_on) begin
            if (sum >= top)
                next_addr = sum - len;
            else if (sum < base)
                next_addr = sum + len;
        end
    end
endmodule

// File: rtl/circ_agu.sv
module circ_agu
    import agu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [SEL_W-1:0]  ptr_sel,
    input  logic [SEL_W-1:0]  dst_sel,
    input  logic [1:0]        mod_kind,
    input  logic [SEL_W-1:0]  mod_reg,
    input  logic [DATA_W-1:0] imm,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              addr_valid,
    output logic [DATA_W-1:0] addr_out
);
    agu_req_t          req;
    logic [DATA_W-1:0] ptr_val, mreg_val, mod_val;
    logic [DATA_W-1:0] base_val, len_val, next_addr, alu_res;
    logic [DATA_W-1:0] wr_data;
    logic [SEL_W-1:0]  wr_sel;
    logic              circ_on, wr_en, is_alu;

    assign req = '{op: agu_op_e'(op_code), ptr: ptr_sel, dst: dst_sel,
                   mk: mod_kind_e'(mod_kind), mreg: mod_reg, imm: imm};

    agu_regfile #(.W(DATA_W), .DEPTH(NREG)) u_rf (
        .clk(clk), .rst(rst),
        .we(wr_en), .wsel(wr_sel), .wdata(wr_data),
        .a_sel(req.ptr), .b_sel(req.mreg), .c_sel(rd_sel),
        .a_data(ptr_val), .b_data(mreg_val), .c_data(rd_data)
    );

    agu_circ_ctx #(.W(DATA_W), .NCIRC(NCIRC), .SW(SEL_W)) u_ctx (
        .clk(clk), .rst(rst),
        .base_we(op_valid && req.op == OP_SBASE),
        .len_we(op_valid && req.op == OP_SLEN),
        .sel(req.ptr), .wdata(req.imm),
        .base_val(base_val), .len_val(len_val), .circ_on(circ_on)
    );

    always_comb begin
        unique case (req.mk)
            MK_REG:  mod_val = mreg_val;
            MK_IMM8: mod_val = sext8(req.imm[7:0]);
            MK_IMM:  mod_val = req.imm;
            default: mod_val = '0;
        endcase
    end

    agu_modwrap #(.W(DATA_W)) u_wrap (
        .ptr(ptr_val), .modv(mod_val), .base(base_val), .len(len_val),
        .circ_on(circ_on), .next_addr(next_addr)
    );

    always_comb begin
        is_alu  = 1'b1;
        alu_res = '0;
        case (req.op)
            OP_ADD:  alu_res = ptr_val + mod_val;
            OP_SUB:  alu_res = ptr_val - mod_val;
            OP_AND:  alu_res = ptr_val & mod_val;
            OP_OR:   alu_res = ptr_val | mod_val;
            default: is_alu  = 1'b0;
        endcase
    end

    always_comb begin
        wr_en   = op_valid && (is_alu || req.op == OP_POST || req.op == OP_LOAD);
        wr_sel  = (req.op == OP_POST) ? req.ptr : req.dst;
        if (req.op == OP_POST)
            wr_data = next_addr;
        else if (req.op == OP_LOAD)
            wr_data = req.imm;
        else
            wr_data = alu_res;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_valid <= 1'b0;
            addr_out   <= '0;
        end else begin
            addr_valid <= op_valid && is_addr_op(req.op);
            if (op_valid && is_addr_op(req.op))
                addr_out <= (req.op == OP_PRE) ? next_addr : ptr_val;
        end
    end
endmodule

// File: rtl/agu_chk.sv
module agu_chk
    import agu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [3:0]        op_code,
    input logic              addr_valid,
    input logic [DATA_W-1:0] addr_out,
    input logic [DATA_W-1:0] ptr_val,
    input logic [DATA_W-1:0] mod_val,
    input logic [DATA_W-1:0] next_addr,
    input logic [DATA_W-1:0] base_val,
    input logic [DATA_W-1:0] len_val,
    input logic              circ_on
);
    logic              pre_op, post_op;
    logic [DATA_W-1:0] mod_mag;
    logic              ptr_in_win;

    assign pre_op     = op_valid && op_code == OP_PRE;
    assign post_op    = op_valid && op_code == OP_POST;
    assign mod_mag    = mod_val[DATA_W-1] ? (~mod_val + 1'b1) : mod_val;
    assign ptr_in_win = (ptr_val >= base_val) && (ptr_val < base_val + len_val);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!addr_valid && addr_out == '0));

    // R3
    pre_addr_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(pre_op) && !$past(rst)) |-> (addr_valid && addr_out == $past(next_addr)));

    // R4
    post_addr_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(post_op) && !$past(rst)) |-> (addr_valid && addr_out == $past(ptr_val)));

    // R6
    wrap_window_chk: assert property (@(posedge clk) disable iff (rst)
        ((pre_op || post_op) && circ_on && ptr_in_win && mod_mag <= len_val)
        |-> (next_addr >= base_val && next_addr < base_val + len_val));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(op_valid) && !$past(rst)) |-> !addr_valid);
endmodule

bind circ_agu agu_chk u_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .addr_valid(addr_valid), .addr_out(addr_out),
    .ptr_val(ptr_val), .mod_val(mod_val), .next_addr(next_addr),
    .base_val(base_val), .len_val(len_val), .circ_on(circ_on)
);

// File: tb/circ_agu_tb.sv
module circ_agu_tb;
    import agu_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] CK_NONE = 2'd0, CK_ADDR = 2'd1, CK_REG = 2'd2;

    typedef struct packed {
        logic [3:0]  op;
        logic [4:0]  ptr;
        logic [4:0]  dst;
        logic [1:0]  mk;
        logic [4:0]  mreg;
        logic [31:0] imm;
        logic [1:0]  ck;
        logic [4:0]  rd;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 40;
    localparam vec_t VECS [NV] = '{
        '{OP_LOAD, 0, 5, MK_IMM, 0, 100, CK_REG, 5, 100, 2},            // R2
        '{OP_LOAD, 0, 6, MK_IMM, 0, 4, CK_REG, 6, 4, 2},                // R2
        '{OP_PRE, 5, 0, MK_REG, 6, 0, CK_ADDR, 0, 104, 3},              // R3 reg modifier
        '{OP_NOP, 0, 0, MK_ZERO, 0, 0, CK_REG, 5, 100, 3},              // R3 pointer kept
        '{OP_POST, 5, 0, MK_IMM8, 0, 32'hFE, CK_ADDR, 0, 100, 4},       // R4
        '{OP_NOP, 0, 0, MK_ZERO, 0, 0, CK_REG, 5, 98, 5},               // R5 imm8 -2
        '{OP_POST, 5, 0, MK_IMM, 0, 16, CK_ADDR, 0, 98, 4},             // R4
        '{OP_NOP, 0, 0, MK_ZERO, 0, 0, CK_REG, 5, 114, 5},              // R5 imm32
        '{OP_LOAD, 0, 1, MK_IMM, 0, 1000, CK_REG, 1, 1000, 2},          // R2
        '{OP_SBASE, 1, 0, MK_ZERO, 0, 1000, CK_NONE, 0, 0, 6},          // R6
        '{OP_SLEN, 1, 0, MK_ZERO, 0, 12, CK_NONE, 0, 0, 6},             // R6
        '{OP_POST, 1, 0, MK_IMM8, 0, 5, CK_ADDR, 0, 1000, 6},           // R6
        '{OP_POST, 1, 0, MK_IMM8, 0, 5, CK_ADDR, 0, 1005, 6},           // R6
        '{OP_POST, 1, 0, MK_IMM8, 0, 5, CK_ADDR, 0, 1010, 6},           // R6
        '{OP_NOP, 0, 0, MK_ZERO, 0, 0, CK_REG, 1, 1003, 6},             // R6 upper wrap
        '{OP_PRE, 1, 0, MK_IMM8, 0, 32'hFB, CK_ADDR, 0, 1010, 6},       // R6 lower wrap pre
        '{OP_NOP, 0, 0, MK_ZERO, 0, 0, CK_REG, 1, 1003, 3},             // R3
        '{OP_POST, 1, 0, MK_IMM8, 0, 32'hFD, CK_ADDR, 0, 1003, 4},      // R4
        '{OP_NOP, 0, 0, MK_ZERO, 0, 0, CK_REG, 1, 1000, 6},             // R6 land on base
        '{OP_POST, 1, 0, MK_IMM8, 0, 32'hFF, CK_ADDR, 0, 1000, 4},      // R4
        '{OP_NOP, 0, 0, MK_ZERO, 0, 0, CK_REG, 1, 1011, 6},             // R6 below base
        '{OP_POST, 1, 0, MK_IMM8, 0, 1, CK_ADDR, 0, 1011, 4},           // R4
        '{OP_NOP, 0, 0, MK_ZERO, 0, 0, CK_REG, 1, 1000, 6},             // R6 exact top
        '{OP_SLEN, 4, 0, MK_ZERO, 0, 8, CK_NONE, 0, 0, 7},              // R7 ignored
        '{OP_LOAD, 0, 4, MK_IMM, 0, 20, CK_REG, 4, 20, 2},              // R2
        '{OP_POST, 4, 0, MK_IMM8, 0, 10, CK_ADDR, 0, 20, 4},            // R4
        '{OP_POST, 4, 0, MK_IMM8, 0, 10, CK_ADDR, 0, 30, 7},            // R7
        '{OP_NOP, 0, 0, MK_ZERO, 0, 0, CK_REG, 4, 40, 7},               // R7 no wrap
        '{OP_LOAD, 0, 2, MK_IMM, 0, 7, CK_REG, 2, 7, 2},                // R2
        '{OP_POST, 2, 0, MK_IMM, 0, 32'hFFFFFFF9, CK_ADDR, 0, 7, 7},    // R7
        '{OP_NOP, 0, 0, MK_ZERO, 0, 0, CK_REG, 2, 0, 7},                // R7 linear len 0
        '{OP_ADD, 5, 10, MK_REG, 6, 0, CK_REG, 10, 118, 8},             // R8 add
        '{OP_SUB, 5, 11, MK_IMM8, 0, 32'h14, CK_REG, 11, 94, 8},        // R8 sub
        '{OP_AND, 5, 12, MK_IMM, 0, 32'hF, CK_REG, 12, 2, 8},           // R8 and
        '{OP_OR, 5, 13, MK_IMM, 0, 32'h100, CK_REG, 13, 32'h172, 8},    // R8 or
        '{OP_ADD, 6, 14, MK_IMM8, 0, 32'h80, CK_REG, 14, 32'hFFFFFF84, 5}, // R5 sign ext
        '{OP_PRE, 5, 0, MK_ZERO, 0, 32'h55, CK_ADDR, 0, 114, 5},        // R5 zero mod
        '{OP_SLEN, 1, 0, MK_ZERO, 0, 0, CK_NONE, 0, 0, 7},              // R7
        '{OP_POST, 1, 0, MK_IMM8, 0, 32'hFB, CK_ADDR, 0, 1000, 7},      // R7
        '{OP_NOP, 0, 0, MK_ZERO, 0, 0, CK_REG, 1, 995, 7}               // R7 len cleared
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [4:0]  ptr_sel = '0, dst_sel = '0, mod_reg = '0, rd_sel = '0;
    logic [1:0]  mod_kind = '0;
    logic [31:0] imm = '0;
    logic [31:0] rd_data, addr_out;
    logic        addr_valid;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    circ_agu u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .ptr_sel(ptr_sel), .dst_sel(dst_sel), .mod_kind(mod_kind),
        .mod_reg(mod_reg), .imm(imm), .rd_sel(rd_sel), .rd_data(rd_data),
        .addr_valid(addr_valid), .addr_out(addr_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic vld);
        op_valid = vld;
        op_code  = v.op;
        ptr_sel  = v.ptr;
        dst_sel  = v.dst;
        mod_kind = v.mk;
        mod_reg  = v.mreg;
        imm      = v.imm;
        rd_sel   = v.rd;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        vec_t t;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        rd_sel = 5;
        check("R1 addr_valid after reset", {31'd0, addr_valid}, 0);
        check("R1 addr_out after reset", addr_out, 0);
        check("R1 register cleared", rd_data, 0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i], 1'b1);
            if (VECS[i].ck == CK_ADDR) begin
                check($sformatf("R%0d vec%0d valid", VECS[i].req, i), {31'd0, addr_valid}, 1);
                check($sformatf("R%0d vec%0d addr", VECS[i].req, i), addr_out, VECS[i].exp);
            end else if (VECS[i].ck == CK_REG) begin
                check($sformatf("R%0d vec%0d reg", VECS[i].req, i), rd_data, VECS[i].exp);
            end
        end

        // R9 op with op_valid low is ignored
        t = '{OP_POST, 5, 0, MK_IMM8, 0, 1, CK_NONE, 5, 0, 9};
        drive(t, 1'b0);
        check("R9 no address when idle", {31'd0, addr_valid}, 0);
        check("R9 pointer untouched when idle", rd_data, 114);

        // R8 ALU op does not raise addr_valid
        t = '{OP_ADD, 5, 15, MK_IMM8, 0, 1, CK_NONE, 15, 0, 8};
        drive(t, 1'b1);
        check("R8 alu no address", {31'd0, addr_valid}, 0);
        check("R8 alu result", rd_data, 115);

        // R1 mid-run reset clears registers and circular context
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        rd_sel = 5;
        check("R1 reg cleared mid run", rd_data, 0);
        check("R1 addr cleared mid run", addr_out, 0);
        t = '{OP_SBASE, 1, 0, MK_ZERO, 0, 0, CK_NONE, 1, 0, 1};
        t.op = OP_POST; t.mk = MK_IMM8; t.imm = 32'hFF;
        drive(t, 1'b1);
        check("R1 length cleared so linear", rd_data, 32'hFFFFFFFF);
        check("R1 post address", addr_out, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule